// File: doc/BRIEF.md
# Eight-bit Arithmetic and Logic Unit with Registered Flags

This block is the arithmetic core of a small eight-bit processor. Two byte operands and a three-bit operation code enter the block; the byte result and a writeback permission leave it in the same cycle, without any register in the path. The block also keeps a registered set of three condition flags: zero, carry and negative. These flags take their new values on a rising clock edge only while the flag-enable input is high, so the surrounding control can decide which instructions affect the condition codes.

Compare works like subtract, but it reports that its result must not be written back. Both shift directions take their amount from the whole second operand. Any amount of eight or more drives the result to zero, and the carry flag keeps the last bit that left the byte. The block does not cover operand muxing, register-file writeback or instruction decode.

Top module: `byte_alu`

## Requirements
- R1: Operation codes on `op_sel`: 0 add, 1 subtract, 2 AND, 3 OR, 4 NOT, 5 compare, 6 shift left, 7 shift right. Add gives `result` = (a + b) mod 256, and its carry is the carry out of bit 7.
- R2: Subtract (code 1) gives `result` = (a - b) mod 256. Its carry is 1 exactly when a is unsigned-less-than b, which is a borrow.
- R3: AND (2) gives a & b, OR (3) gives a | b, and NOT (4) gives ~a with b ignored. All three produce a carry of 0.
- R4: Compare (5) produces the same result and flags as subtract, with `wb_en` low. Every other code drives `wb_en` high.
- R5: Shift left (6) by b: for b = 0 the result is a and the carry is 0. For 1 ≤ b ≤ 8 the result is (a << b) mod 256 and the carry is bit 8-b of a. For b > 8 the result is 0 and the carry is 0.
- R6: Shift right (7) by b: for b = 0 the result is a and the carry is 0. For 1 ≤ b ≤ 8 the result is a >> b and the carry is bit b-1 of a. For b > 8 the result is 0 and the carry is 0.
- R7: After an enabled edge, `flag_z` is 1 exactly when the result presented before that edge was 0x00.
- R8: After an enabled edge, `flag_n` equals bit 7 of the result presented before that edge. `flag_c` takes the carry of that operation.
- R9: While `flag_en` is low at a rising edge, all three flags keep their values.
- R10: A rising edge with `rst_n` low clears all three flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand or shift amount |
| flag_en | input | 1 | Commits the new flags at the next edge |
| result | output | 8 | Combinational result |
| wb_en | output | 1 | High when the result may be written back |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry or borrow flag |
| flag_n | output | 1 | Registered negative flag |

## Verification
`result` and `wb_en` are due in the same cycle as the inputs that produce them. The bench drives inputs just after a falling edge and compares these two outputs one nanosecond later, before the next rising edge. The flags are due one rising edge later. The reference model updates its own flag copy at that edge, and the bench compares all three flags one nanosecond after it, before the inputs change again. Directed corner vectors come first: wrap-around, borrow, equality, and shift amounts 0, 1, 7, 8 and 9. A random run with `flag_en` toggled at random follows them.

// File: rtl/byte_alu_pkg.sv
// Package: shared operation codes and flag bundle for the byte ALU.
// Assumes: codes are fixed because the decoder outside drives them.
package byte_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_NOT = 3'd4,
        OP_CMP = 3'd5,
        OP_SHL = 3'd6,
        OP_SHR = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
    } alu_flags_t;

endpackage

// File: rtl/byte_alu_addsub.sv
// Module: adder/subtractor over W bits.
// Does: a + b, or a - b through two's complement. Reports carry on add
// and borrow (a unsigned-less-than b) on subtract.
// Assumes: purely combinational, no reset needed.
module byte_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         do_sub,
    output logic [W-1:0] sum_out,
    output logic         cy_out
);
    logic [W:0]   wide_sum;
    logic [W-1:0] b_eff;

    // Select the true or inverted second operand and form the wide sum.
    always_comb begin
        b_eff    = do_sub ? ~b_in : b_in;
        wide_sum = {1'b0, a_in} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
        sum_out  = wide_sum[W-1:0];
        cy_out   = do_sub ? ~wide_sum[W] : wide_sum[W];
    end
endmodule

// File: rtl/byte_alu_shift.sv
// Module: one-direction variable shifter over W bits.
// Does: shifts by the full amt value, zero fill. cy_out holds the last
// bit pushed out; amounts of W or more give a zero result.
// Assumes: LEFT selects the direction at elaboration time.
module byte_alu_shift #(
    parameter int W    = 8,
    parameter bit LEFT = 1'b1
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] amt,
    output logic [W-1:0] sh_out,
    output logic         cy_out
);
    logic [W:0] ext;

    generate
        if (LEFT) begin : g_left
            // Shift with a guard bit above the MSB to catch the last bit out.
            always_comb begin
                ext    = {1'b0, a_in} << amt;
                sh_out = ext[W-1:0];
                cy_out = ext[W];
            end
        end else begin : g_right
            // Shift with a guard bit below the LSB to catch the last bit out.
            always_comb begin
                ext    = {a_in, 1'b0} >> amt;
                sh_out = ext[W:1];
                cy_out = ext[0];
            end
        end
    endgenerate
endmodule

// File: rtl/byte_alu_flagreg.sv
// Module: condition flag register.
// Does: loads the three flags on a rising edge while ld_en is high.
// Assumes: synchronous active-low reset clears every flag.
module byte_alu_flagreg
    import byte_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_en,
    input  alu_flags_t d_in,
    output alu_flags_t q_out
);
    // Hold or load the flags; reset wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_out <= '0;
        else if (ld_en)
            q_out <= d_in;
    end

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld_en)) |-> $stable(q_out))
        else $error("flags changed while load disabled");

    p_reset_clear_r10: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (q_out == '0))
        else $error("flags not cleared by reset");
endmodule

// File: rtl/byte_alu.sv
// Module: top of the byte ALU.
// Does: combinational result and writeback permission, plus registered
// zero/carry/negative flags committed when flag_en is high.
// Assumes: op_sel codes follow byte_alu_pkg; shift amount is all of opnd_b.
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         flag_en,
    output logic [W-1:0] result,
    output logic         wb_en,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_n
);
    localparam int MSB = W - 1;

    alu_op_e     op;
    logic        use_sub;
    logic [W-1:0] as_res, shl_res, shr_res;
    logic        as_cy, shl_cy, shr_cy;
    logic        nxt_c;
    alu_flags_t  nxt_flags, cur_flags;

    // Interpret the raw code and choose subtract mode for SUB and CMP.
    always_comb begin
        op      = alu_op_e'(op_sel);
        use_sub = (op == OP_SUB) || (op == OP_CMP);
    end

    byte_alu_addsub #(.W(W)) u_addsub (
        .a_in(opnd_a), .b_in(opnd_b), .do_sub(use_sub),
        .sum_out(as_res), .cy_out(as_cy)
    );

    byte_alu_shift #(.W(W), .LEFT(1'b1)) u_shl (
        .a_in(opnd_a), .amt(opnd_b), .sh_out(shl_res), .cy_out(shl_cy)
    );

    byte_alu_shift #(.W(W), .LEFT(1'b0)) u_shr (
        .a_in(opnd_a), .amt(opnd_b), .sh_out(shr_res), .cy_out(shr_cy)
    );

    // Pick the result and carry of the selected operation.
    always_comb begin
        result = as_res;
        nxt_c  = as_cy;
        wb_en  = 1'b1;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result = as_res;
                nxt_c  = as_cy;
            end
            OP_CMP: begin
                result = as_res;
                nxt_c  = as_cy;
                wb_en  = 1'b0;
            end
            OP_AND: begin
                result = opnd_a & opnd_b;
                nxt_c  = 1'b0;
            end
            OP_OR: begin
                result = opnd_a | opnd_b;
                nxt_c  = 1'b0;
            end
            OP_NOT: begin
                result = ~opnd_a;
                nxt_c  = 1'b0;
            end
            OP_SHL: begin
                result = shl_res;
                nxt_c  = shl_cy;
            end
            OP_SHR: begin
                result = shr_res;
                nxt_c  = shr_cy;
            end
            default: begin
                result = as_res;
                nxt_c  = as_cy;
            end
        endcase
    end

    // Assemble the candidate flags from the chosen result.
    always_comb begin
        nxt_flags.z = (result == '0);
        nxt_flags.c = nxt_c;
        nxt_flags.n = result[MSB];
    end

    byte_alu_flagreg u_flags (
        .clk(clk), .rst_n(rst_n), .ld_en(flag_en),
        .d_in(nxt_flags), .q_out(cur_flags)
    );

    // Drive the flag ports from the register.
    always_comb begin
        flag_z = cur_flags.z;
        flag_c = cur_flags.c;
        flag_n = cur_flags.n;
    end

    // Writeback permission is low for compare only (R4).
    always_comb begin
        p_cmp_no_wb_r4: assert (rst_n !== 1'b1 || (wb_en == (op_sel != 3'd5)))
            else $error("wb_en wrong for op %0d", op_sel);
    end

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_en)) |-> (flag_z == ($past(result) == '0)))
        else $error("zero flag mismatch");

    p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_en)) |-> (flag_n == $past(result[MSB])))
        else $error("negative flag mismatch");

    p_logic_clears_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_en) &&
         ($past(op_sel) == 3'd2 || $past(op_sel) == 3'd3 || $past(op_sel) == 3'd4))
        |-> !flag_c)
        else $error("logic op left carry set");
endmodule

// File: tb/byte_alu_tb.sv
module byte_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] opnd_a = 8'd0, opnd_b = 8'd0;
    logic       flag_en = 1'b0;
    logic [7:0] result;
    logic       wb_en, flag_z, flag_c, flag_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural model state.
    bit m_z = 0, m_c = 0, m_n = 0;

    always #4 clk = ~clk;  // 125 MHz

    byte_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .flag_en(flag_en), .result(result), .wb_en(wb_en),
        .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference: returns result in [7:0] and carry in [8].
    function automatic int ref_op(input int op, input int a, input int b);
        int r, c;
        case (op)
            0: begin r = a + b; c = (r > 255); end
            1, 5: begin r = a - b; c = (a < b); end
            2: begin r = a & b; c = 0; end
            3: begin r = a | b; c = 0; end
            4: begin r = 255 - a; c = 0; end
            6: begin
                if (b == 0) begin r = a; c = 0; end
                else if (b <= 8) begin r = a * (1 << b); c = (a / (1 << (8 - b))) % 2; end
                else begin r = 0; c = 0; end
            end
            default: begin
                if (b == 0) begin r = a; c = 0; end
                else if (b <= 8) begin r = a / (1 << b); c = (a / (1 << (b - 1))) % 2; end
                else begin r = 0; c = 0; end
            end
        endcase
        r = ((r % 256) + 256) % 256;
        return r + c * 256;
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R3";
            5: return "R4";
            6: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic step(input int op, input int a, input int b, input bit en);
        int rv, er, ec;
        @(negedge clk);
        op_sel = op[2:0]; opnd_a = a[7:0]; opnd_b = b[7:0]; flag_en = en;
        rv = ref_op(op, a, b);
        er = rv % 256;
        ec = rv / 256;
        #1;
        chk(req_of(op), int'(result), er);
        chk("R4", int'(wb_en), (op == 5) ? 0 : 1);
        @(posedge clk);
        if (en) begin
            m_z = (er == 0);
            m_c = ec[0];
            m_n = er[7];
        end
        #1;
        chk(en ? "R7" : "R9", int'(flag_z), int'(m_z));
        chk(en ? "R8" : "R9", int'(flag_c), int'(m_c));
        chk(en ? "R8" : "R9", int'(flag_n), int'(m_n));
    endtask

    initial begin
        // Watchdog.
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R10: reset clears flags after set values.
        repeat (3) @(posedge clk);
        #1;
        chk("R10", {29'd0, flag_z, flag_c, flag_n}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 255, 1, 1);      // wrap to 0: Z=1, C=1
        step(1, 16, 32, 1);      // borrow, negative
        @(negedge clk); rst_n = 1'b0; flag_en = 1'b0;
        @(posedge clk); #1;
        chk("R10", {29'd0, flag_z, flag_c, flag_n}, 0);
        @(negedge clk); rst_n = 1'b1;

        // Directed corners.
        step(0, 8'h7f, 1, 1);    // R1 add to 0x80, N=1
        step(0, 200, 100, 1);    // R1 carry
        step(1, 50, 50, 1);      // R2 zero, no borrow
        step(1, 1, 2, 1);        // R2 borrow
        step(5, 33, 33, 1);      // R4 equal compare
        step(5, 3, 9, 1);        // R4 borrow
        step(2, 8'hf0, 8'h3c, 1); // R3
        step(3, 8'h0f, 8'h80, 1); // R3
        step(4, 8'hff, 8'h55, 1); // R3 NOT to zero, b ignored
        step(6, 8'h81, 0, 1);    // R5 amount 0
        step(6, 8'h81, 1, 1);    // R5 carry out of bit 7
        step(6, 8'h01, 7, 1);    // R5
        step(6, 8'h01, 8, 1);    // R5 amount 8: C=a[0]
        step(6, 8'hff, 9, 1);    // R5 amount 9
        step(7, 8'h81, 1, 1);    // R6
        step(7, 8'h80, 7, 1);    // R6
        step(7, 8'h80, 8, 1);    // R6 amount 8: C=a[7]
        step(7, 8'hff, 200, 1);  // R6 large amount
        step(0, 255, 1, 1);      // set Z and C
        step(4, 0, 0, 0);        // R9 disabled: flags must stay
        step(7, 8'h80, 8, 0);    // R9

        // Random run.
        for (int i = 0; i < 400; i++) begin
            int op, a, b;
            op = $urandom_range(0, 7);
            a  = $urandom_range(0, 255);
            b  = (op >= 6) ? $urandom_range(0, 12) : $urandom_range(0, 255);
            step(op, a, b, ($urandom_range(0, 3) != 0));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule